// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital half of an integrating analog-to-digital converter whose analog half is built from parts outside the chip: an analog multiplexer, an integrator and a comparator. A start pulse begins a conversion. The block first holds its multiplexer-select output in the position that feeds the unknown voltage to the integrator. It keeps it there for a programmed number of prescaled ticks. It then switches the select to the reference voltage and counts ticks until the comparator reports that the integrator has crossed back. That count is the conversion result.

Both phases use one prescaler. Its tick period is a power of two of the clock, chosen by a select input. The comparator is normally active-low. An invert input makes it active-high. The comparator input passes through a two-flop synchronizer before any decision uses it. A reference phase that reaches the full-scale count without an end-of-conversion stops on its own and reports a saturated, flagged result.

The sequencer has four states. ST_IDLE waits for a start. ST_RUNUP integrates the unknown input. ST_RUNDOWN integrates the reference and counts. ST_FINISH is a single cycle that reports completion. The transitions are:
- idle-to-runup: start with a nonzero period.
- idle-to-rundown: start with a zero period.
- runup-to-rundown: the last run-up tick.
- rundown-to-finish: end-of-conversion, or saturation.
- finish-to-idle: always, after one cycle.

Top module: `dsadc_ctrl`

## Requirements
- R1: During and after reset, the block is idle with mux_ref_o=0 (unknown input selected), busy_o=0, done_o=0, result_o=0 and overflow_o=0.
- R2: One tick lasts 2^(sel+1) clock cycles, where sel is the value of presc_sel_i latched at start. The select is 4 bits wide. When WIDE_SEL=0, bit 3 is ignored and sel ranges 0..7.
- R3: After an accepted start, mux_ref_o stays 0 for exactly period_i × 2^(sel+1) cycles and then rises to 1 (reference selected). It returns to 0 when the conversion completes.
- R4: A period_i of zero skips the run-up phase. mux_ref_o is 1 from the first cycle after the start.
- R5: During the reference phase the block counts completed ticks. The result is the number of ticks completed before the synchronized end-of-conversion is acted upon. A comparator change made during cycle c is acted upon at the third rising edge after it. A tick that falls on that same edge is not counted.
- R6: With eoc_invert_i=0, a low comparator level ends the reference phase. With eoc_invert_i=1, a high level ends it. The comparator's opposite level never ends it.
- R7: If the reference count is at 16'hFFFF when another tick completes, the conversion ends with result_o=16'hFFFF and overflow_o=1. A normal end clears overflow_o.
- R8: start_i is acted on only in ST_IDLE. A start while busy changes neither the running conversion nor its latched period, select or polarity.
- R9: busy_o is high from the cycle after an accepted start until the conversion ends. done_o is a one-cycle pulse with busy_o low.
- R10: result_o and overflow_o change only in the cycle that done_o is asserted, and hold their values until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, acted on only when idle |
| period_i | input | CTRL_W | Run-up length in ticks |
| presc_sel_i | input | 4 | Prescaler select, tick = 2^(sel+1) clocks |
| eoc_invert_i | input | 1 | 1: comparator is active-high |
| cmp_i | input | 1 | Asynchronous comparator output |
| mux_ref_o | output | 1 | 0: unknown input routed, 1: reference routed |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | RES_W | Reference-phase tick count |
| overflow_o | output | 1 | Last result saturated |

## Verification
The hardest situation to reach is saturation. The reference phase must run 65536 ticks with the comparator held idle. The bench reaches it with the smallest prescaler, so the phase lasts about 131 thousand cycles. Exact result values depend on the phase alignment between the prescaler and the synchronizer latency. The bench therefore asserts the comparator a fixed number of cycles after it sees the select flip. It predicts floor((N+2)/tick) from R5, and uses offsets that land on and beside tick boundaries. Ignored starts are driven inside the reference phase with a different period, and the bench checks that the result and the select timing are unaffected.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

    localparam int SEL_PORT_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUNUP,
        ST_RUNDOWN,
        ST_FINISH
    } seq_state_e;

endpackage

// File: rtl/dsadc_tick_gen.sv
module dsadc_tick_gen #(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             run_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int CW = 1 << SEL_W;
    localparam int IW = SEL_W + 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;

    // limit = 2^(sel+1) - 1 built as a thermometer mask
    always_comb begin
        for (int i = 0; i < CW; i++) begin
            limit[i] = (IW'(i) <= {1'b0, sel_i});
        end
    end

    assign tick_o = run_i && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (run_i) begin
            cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
        end
    end

    // R2: a tick period is at least two cycles
    assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    assert_clear_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !tick_o);

endmodule

// File: rtl/dsadc_sync.sv
module dsadc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= {STAGES{RST_VAL}};
        end else begin
            stg_q <= {stg_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
    import dsadc_pkg::*;
#(
    parameter int CTRL_W = 16,
    parameter int RES_W  = 16,
    parameter int SEL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CTRL_W-1:0] period_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic              inv_i,
    input  logic              cmp_sync_i,
    input  logic              tick_i,
    output logic [SEL_W-1:0]  sel_o,
    output logic              pre_clr_o,
    output logic              run_o,
    output logic              mux_ref_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [RES_W-1:0]  result_o,
    output logic              overflow_o
);
    localparam logic [CTRL_W-1:0] ONE_C   = CTRL_W'(1);
    localparam logic [RES_W-1:0]  RES_MAX = {RES_W{1'b1}};

    seq_state_e        state_q, state_d;
    logic [CTRL_W-1:0] ctrl_q;
    logic [CTRL_W-1:0] phase_cnt_q;
    logic [RES_W-1:0]  res_cnt_q;
    logic [RES_W-1:0]  result_q;
    logic              ovf_q;
    logic              inv_q;
    logic [SEL_W-1:0]  sel_q;
    logic              eoc_act;
    logic              accept;
    logic              runup_last;
    logic              sat_hit;

    assign eoc_act    = inv_q ? cmp_sync_i : ~cmp_sync_i;
    assign accept     = (state_q == ST_IDLE) && start_i;
    assign runup_last = tick_i && (phase_cnt_q == ctrl_q - ONE_C);
    assign sat_hit    = tick_i && (res_cnt_q == RES_MAX);

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = (period_i == '0) ? ST_RUNDOWN : ST_RUNUP;
                end
            end
            ST_RUNUP: begin
                if (runup_last) state_d = ST_RUNDOWN;
            end
            ST_RUNDOWN: begin
                if (eoc_act || sat_hit) state_d = ST_FINISH;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q      <= '0;
            sel_q       <= '0;
            inv_q       <= 1'b0;
            phase_cnt_q <= '0;
            res_cnt_q   <= '0;
            result_q    <= '0;
            ovf_q       <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        ctrl_q      <= period_i;
                        sel_q       <= sel_i;
                        inv_q       <= inv_i;
                        phase_cnt_q <= '0;
                        res_cnt_q   <= '0;
                    end
                end
                ST_RUNUP: begin
                    if (tick_i) phase_cnt_q <= phase_cnt_q + ONE_C;
                end
                ST_RUNDOWN: begin
                    if (eoc_act) begin
                        result_q <= res_cnt_q;
                        ovf_q    <= 1'b0;
                    end else if (sat_hit) begin
                        result_q <= RES_MAX;
                        ovf_q    <= 1'b1;
                    end else if (tick_i) begin
                        res_cnt_q <= res_cnt_q + 1'b1;
                    end
                end
                ST_FINISH: ;
                default: ;
            endcase
        end
    end

    // output decode
    always_comb begin
        mux_ref_o  = (state_q == ST_RUNDOWN);
        busy_o     = (state_q == ST_RUNUP) || (state_q == ST_RUNDOWN);
        done_o     = (state_q == ST_FINISH);
        run_o      = busy_o;
        pre_clr_o  = accept || ((state_q == ST_RUNUP) && runup_last);
        sel_o      = sel_q;
        result_o   = result_q;
        overflow_o = ovf_q;
    end

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_busy_after_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy_o);
    assert_zero_skip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && period_i == '0) |=> mux_ref_o);
    assert_busy_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(ctrl_q) && $stable(sel_q) && $stable(inv_q)));
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow_o) |-> (result_o == RES_MAX));
    assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(result_o) && $stable(overflow_o)));

endmodule

// File: rtl/dsadc_ctrl.sv
module dsadc_ctrl
    import dsadc_pkg::*;
#(
    parameter int CTRL_W   = 16,
    parameter int RES_W    = 16,
    parameter bit WIDE_SEL = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [CTRL_W-1:0]     period_i,
    input  logic [SEL_PORT_W-1:0] presc_sel_i,
    input  logic                  eoc_invert_i,
    input  logic                  cmp_i,
    output logic                  mux_ref_o,
    output logic                  busy_o,
    output logic                  done_o,
    output logic [RES_W-1:0]      result_o,
    output logic                  overflow_o
);
    localparam int SEL_W = WIDE_SEL ? SEL_PORT_W : SEL_PORT_W - 1;

    logic [SEL_W-1:0] sel_eff;
    logic [SEL_W-1:0] sel_lat;
    logic             cmp_sync;
    logic             tick;
    logic             pre_clr;
    logic             run;

    generate
        if (WIDE_SEL) begin : g_sel_wide
            assign sel_eff = presc_sel_i;
        end else begin : g_sel_narrow
            assign sel_eff = presc_sel_i[SEL_W-1:0];
        end
    endgenerate

    dsadc_sync #(
        .STAGES  (2),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (cmp_i),
        .q_o   (cmp_sync)
    );

    dsadc_tick_gen #(
        .SEL_W (SEL_W)
    ) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (pre_clr),
        .run_i   (run),
        .sel_i   (sel_lat),
        .tick_o  (tick)
    );

    dsadc_seq #(
        .CTRL_W (CTRL_W),
        .RES_W  (RES_W),
        .SEL_W  (SEL_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .period_i   (period_i),
        .sel_i      (sel_eff),
        .inv_i      (eoc_invert_i),
        .cmp_sync_i (cmp_sync),
        .tick_i     (tick),
        .sel_o      (sel_lat),
        .pre_clr_o  (pre_clr),
        .run_o      (run),
        .mux_ref_o  (mux_ref_o),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .result_o   (result_o),
        .overflow_o (overflow_o)
    );

    assert_idle_unknown_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mux_ref_o);

endmodule

// File: tb/tb_dsadc_ctrl.sv
module tb_dsadc_ctrl;

    typedef struct packed {
        logic [15:0] res;
        logic        ovf;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] period_i = '0;
    logic [3:0]  presc_sel_i = '0;
    logic        eoc_invert_i = 1'b0;
    logic        cmp_i = 1'b1;
    logic        mux_ref_o, busy_o, done_o, overflow_o;
    logic [15:0] result_o;

    int   total = 0;
    int   bad = 0;
    bit   finished = 1'b0;
    bit   prev_done = 1'b0;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    dsadc_ctrl dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .period_i     (period_i),
        .presc_sel_i  (presc_sel_i),
        .eoc_invert_i (eoc_invert_i),
        .cmp_i        (cmp_i),
        .mux_ref_o    (mux_ref_o),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .result_o     (result_o),
        .overflow_o   (overflow_o)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: pops scoreboard on each done pulse
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (prev_done) chk(!done_o, "R9 done lasts one cycle", done_o, 0);
            if (done_o) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R5 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(result_o == e.res, "R5/R7 result", result_o, e.res);
                    chk(overflow_o == e.ovf, "R7 overflow flag", overflow_o, e.ovf);
                end
                chk(!busy_o, "R9 busy low at done", busy_o, 0);
                chk(!mux_ref_o, "R3 select back to unknown at done", mux_ref_o, 0);
            end
            prev_done = done_o;
        end
    end

    // driver: one conversion; n = cycles from select flip to comparator assertion
    task automatic conv(input int ctrl, input int sel, input bit inv, input int n,
                        input bit sat, input bit poke);
        int   per;
        int   k;
        exp_t e;
        logic [15:0] held;
        per = 1 << (sel + 1);
        period_i = 16'(ctrl);
        presc_sel_i = 4'(sel);
        eoc_invert_i = inv;
        cmp_i = inv ? 1'b0 : 1'b1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        k = 1;
        chk(busy_o, "R9 busy after start", busy_o, 1);
        while (!mux_ref_o) begin
            @(negedge clk);
            k++;
        end
        chk(k == ctrl * per + 1, (ctrl == 0) ? "R4 zero period skips run-up" : "R3/R2 run-up length",
            k, ctrl * per + 1);
        if (sat) begin
            e.res = 16'hFFFF;
            e.ovf = 1'b1;
        end else begin
            e.res = 16'((n + 2) / per);
            e.ovf = 1'b0;
        end
        sb_q.push_back(e);
        if (!sat) begin
            for (int i = 0; i < n; i++) begin
                if (poke && i == 1) begin
                    period_i = 16'd99;
                    presc_sel_i = 4'd0;
                    eoc_invert_i = ~inv;
                    start_i = 1'b1;
                end else begin
                    start_i = 1'b0;
                end
                @(negedge clk);
            end
            start_i = 1'b0;
            if (poke) chk(mux_ref_o, "R8 start ignored while busy", mux_ref_o, 1);
            cmp_i = inv ? 1'b1 : 1'b0;
        end
        while (!done_o) @(negedge clk);
        held = result_o;
        @(negedge clk);
        cmp_i = inv ? 1'b0 : 1'b1;
        repeat (6) @(negedge clk);
        chk(result_o == held, "R10 result held after done", result_o, held);
        chk(!busy_o && !mux_ref_o, "R1 back to idle", busy_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!mux_ref_o, "R1 reset select", mux_ref_o, 0);
        chk(!busy_o, "R1 reset busy", busy_o, 0);
        chk(!done_o, "R1 reset done", done_o, 0);
        chk(result_o == 0 && !overflow_o, "R1 reset result", result_o, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy_o && !mux_ref_o, "R1 idle after reset", busy_o, 0);

        conv(3, 0, 1'b0, 20, 1'b0, 1'b0);    // R5 R6 active-low
        conv(5, 2, 1'b0, 45, 1'b0, 1'b0);    // R2 sel=2
        conv(0, 1, 1'b0, 13, 1'b0, 1'b0);    // R4
        conv(4, 1, 1'b1, 30, 1'b0, 1'b0);    // R6 inverted
        conv(2, 0, 1'b0, 0, 1'b0, 1'b0);     // R5 earliest end
        conv(1, 9, 1'b1, 2500, 1'b0, 1'b0);  // R2 wide select
        conv(6, 1, 1'b0, 26, 1'b0, 1'b1);    // R8 ignored start
        conv(1, 0, 1'b0, 0, 1'b1, 1'b0);     // R7 saturation
        chk(overflow_o, "R10 overflow held", overflow_o, 1);
        conv(2, 0, 1'b0, 6, 1'b0, 1'b0);     // R7 normal end clears flag
        chk(sb_q.size() == 0, "R5 all results seen", sb_q.size(), 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog R9 actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule